// File: doc/BRIEF.md
# Burst bus initiator

This block is the master side of a synchronous, shared parallel bus. Its framing and handshake lines are active low. A local client asks for a burst by giving a direction, a start word address and a word count. The initiator then runs the whole bus transaction by itself:

- It drives an address phase with a command code.
- On reads, it leaves the shared address/data lines undriven for one cycle so the other side can take them over.
- It moves one word on every clock edge where both ready lines are low. Cycles where either side is not ready become wait states.
- It signals the final word by releasing the framing line while its own ready line stays low.

Write data comes from the local side on a valid/ready stream. When that stream has no word available, the initiator holds its ready line high instead of giving up the burst. Read words are delivered back to the local side one cycle after the bus edge on which they moved. A word address counter starts at the request address and advances once per completed data phase. It is visible at a port.

Top module: `burst_initiator`

## Requirements
- R1: After reset, the framing line and the initiator-ready line are high, the address/data drivers are disabled, `rd_valid` is low and `req_ready` is high.
- R2: A request is taken on an edge where `req_valid` and `req_ready` are both high. In the cycle that follows:
  - the framing line is low;
  - the address/data lines are driven with the start address, zero-extended;
  - the command lines carry 4'b0111 for a write or 4'b0110 for a read.
- R3: A word moves only on a rising edge where the initiator-ready and target-ready lines are both low. While the target is not ready, a presented write word and the low initiator-ready line are held unchanged.
- R4: A burst moves exactly `req_len` + 1 words, for any `req_len`. No more write words are requested from the local side once that many have been taken.
- R5: Within a burst, the framing line is high only while the initiator-ready line is low and exactly one transfer remains. Otherwise it stays low.
- R6: In a read, the cycle after the address phase is a turnaround: the address/data drivers are disabled and the initiator-ready line is high. From then on, the initiator-ready line stays low until the last word.
- R7: In the cycle after the final transfer, both control lines are high, the drivers are off and `req_ready` is high. The next address phase comes no earlier than one full idle cycle later.
- R8: During a write, the initiator-ready line is low exactly when a word taken from the local stream is waiting to move. A local stall keeps it high without ending the burst, and words go out in the order they were taken.
- R9: On each transfer edge, `cur_addr` equals the start address plus the number of words already moved, modulo 2^AW.
- R10: For each read transfer, `rd_valid` is high for exactly the next cycle, with `rd_data` equal to the word sampled from the bus. At all other times `rd_valid` is low.
- R11: Whenever the initiator-ready line is low, the command lines carry 4'b0000, meaning all byte lanes are enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every bus line is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Local request present |
| req_ready | output | 1 | Initiator idle and able to take a request |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_addr | input | AW | Start word address |
| req_len | input | LW | Number of words minus one |
| wr_valid | input | 1 | Local write word available |
| wr_ready | output | 1 | Initiator takes the local write word this edge |
| wr_data | input | DW | Local write word |
| rd_valid | output | 1 | Read word delivered this cycle |
| rd_data | output | DW | Delivered read word |
| cur_addr | output | AW | Word address of the current data phase |
| bus_cyc_n | output | 1 | Framing line, low while a transaction is in progress |
| bus_mrdy_n | output | 1 | Initiator-ready line |
| bus_srdy_n | input | 1 | Target-ready line |
| bus_cmd_o | output | 4 | Command during the address phase, byte enables during data phases |
| bus_ad_oe | output | 1 | Drive enable for the shared address/data lines |
| bus_ad_o | output | DW | Address or write data driven onto the shared lines |
| bus_ad_i | input | DW | Value sampled from the shared lines |

## Verification
The bench builds the block with DW=16, AW=8 and LW=3. This covers every burst length from one to eight words in both directions, including the single-word case where framing is released on the first data phase. Each length and direction runs under three mixes of target wait states and local write stalls, from none to heavy. Some start addresses sit near the top of the 8-bit space, so the address counter wraps inside a burst.

// File: rtl/bi_pkg.sv
package bi_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_TURN,
    ST_DATA
  } bi_state_t;

  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;
  localparam logic [3:0] BE_ALL     = 4'b0000;
endpackage

// File: rtl/bi_ctr.sv
// Loadable counter; UP selects an incrementer or a floor-at-zero decrementer.
module bi_ctr #(
  parameter int W  = 8,
  parameter bit UP = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] init,
  output logic [W-1:0] value
);
  logic [W-1:0] q;

  generate
    if (UP) begin : g_up
      always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= init;
        else if (step) q <= q + W'(1);
      end
    end else begin : g_dn
      always_ff @(posedge clk) begin
        if (rst)                     q <= '0;
        else if (load)               q <= init;
        else if (step && q != '0)    q <= q - W'(1);
      end
    end
  endgenerate

  assign value = q;
endmodule

// File: rtl/bi_rdcap.sv
// Registers a read word from the bus and flags it for one cycle.
module bi_rdcap #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic [DW-1:0] din,
  output logic          valid,
  output logic [DW-1:0] dout
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      dout  <= '0;
    end else begin
      valid <= take;
      if (take) dout <= din;
    end
  end
endmodule

// File: rtl/burst_initiator.sv
module burst_initiator
  import bi_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 16,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [LW-1:0] req_len,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [DW-1:0] wr_data,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] cur_addr,
  output logic          bus_cyc_n,
  output logic          bus_mrdy_n,
  input  logic          bus_srdy_n,
  output logic [3:0]    bus_cmd_o,
  output logic          bus_ad_oe,
  output logic [DW-1:0] bus_ad_o,
  input  logic [DW-1:0] bus_ad_i
);
  localparam int CW = LW + 1;

  bi_state_t     st_q, st_d;
  logic          wr_q;
  logic          cyc_d, mrdy_d, oe_d;
  logic [DW-1:0] ad_d;
  logic [3:0]    cmd_d;
  logic          accept, xfer, wr_fire, slot_free;
  logic          rem_one, rem_two;
  logic [CW-1:0] rem_val, fch_val, len_words;

  assign len_words = CW'(req_len) + CW'(1);
  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign xfer      = (st_q == ST_DATA) && !bus_mrdy_n && !bus_srdy_n;
  assign rem_one   = (rem_val == CW'(1));
  assign rem_two   = (rem_val == CW'(2));
  // The write holding slot is free in the address phase, when no word waits,
  // or when the waiting word moves on this edge.
  assign slot_free = (st_q == ST_ADDR) || ((st_q == ST_DATA) && (bus_mrdy_n || xfer));
  assign wr_ready  = wr_q && slot_free && (fch_val != '0);
  assign wr_fire   = wr_valid && wr_ready;

  // Words still to move on the bus
  bi_ctr #(.W(CW), .UP(1'b0)) u_rem (
    .clk(clk), .rst(rst), .load(accept), .step(xfer),
    .init(len_words), .value(rem_val)
  );

  // Write words still to take from the local stream
  bi_ctr #(.W(CW), .UP(1'b0)) u_fch (
    .clk(clk), .rst(rst), .load(accept), .step(wr_fire),
    .init(len_words), .value(fch_val)
  );

  // Word address of the current data phase
  bi_ctr #(.W(AW), .UP(1'b1)) u_adr (
    .clk(clk), .rst(rst), .load(accept), .step(xfer),
    .init(req_addr), .value(cur_addr)
  );

  bi_rdcap #(.DW(DW)) u_rd (
    .clk(clk), .rst(rst), .take(xfer && !wr_q),
    .din(bus_ad_i), .valid(rd_valid), .dout(rd_data)
  );

  always_comb begin
    st_d   = st_q;
    cyc_d  = bus_cyc_n;
    mrdy_d = bus_mrdy_n;
    oe_d   = bus_ad_oe;
    ad_d   = bus_ad_o;
    cmd_d  = bus_cmd_o;
    case (st_q)
      ST_IDLE: begin
        cyc_d  = 1'b1;
        mrdy_d = 1'b1;
        oe_d   = 1'b0;
        if (accept) begin
          st_d  = ST_ADDR;
          cyc_d = 1'b0;
          oe_d  = 1'b1;
          ad_d  = DW'(req_addr);
          cmd_d = req_write ? CMD_MEM_WR : CMD_MEM_RD;
        end
      end
      ST_ADDR: begin
        cmd_d = BE_ALL;
        if (wr_q) begin
          st_d   = ST_DATA;
          mrdy_d = !wr_fire;
          if (wr_fire) ad_d = wr_data;
          cyc_d  = wr_fire && rem_one;
        end else begin
          st_d = ST_TURN;
          oe_d = 1'b0;
        end
      end
      ST_TURN: begin
        st_d   = ST_DATA;
        mrdy_d = 1'b0;
        cyc_d  = rem_one;
      end
      ST_DATA: begin
        if (xfer && rem_one) begin
          st_d   = ST_IDLE;
          cyc_d  = 1'b1;
          mrdy_d = 1'b1;
          oe_d   = 1'b0;
        end else if (wr_q) begin
          if (slot_free) begin
            mrdy_d = !wr_fire;
            if (wr_fire) ad_d = wr_data;
          end
          cyc_d = !mrdy_d && (xfer ? rem_two : rem_one);
        end else begin
          cyc_d = xfer ? rem_two : rem_one;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      wr_q       <= 1'b0;
      bus_cyc_n  <= 1'b1;
      bus_mrdy_n <= 1'b1;
      bus_ad_oe  <= 1'b0;
      bus_ad_o   <= '0;
      bus_cmd_o  <= BE_ALL;
    end else begin
      st_q       <= st_d;
      if (accept) wr_q <= req_write;
      bus_cyc_n  <= cyc_d;
      bus_mrdy_n <= mrdy_d;
      bus_ad_oe  <= oe_d;
      bus_ad_o   <= ad_d;
      bus_cmd_o  <= cmd_d;
    end
  end
endmodule

// File: rtl/bi_chk.sv
module bi_chk
  import bi_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          req_ready,
  input logic          rd_valid,
  input logic [AW-1:0] cur_addr,
  input logic          bus_cyc_n,
  input logic          bus_mrdy_n,
  input logic          bus_srdy_n,
  input logic [3:0]    bus_cmd_o,
  input logic          bus_ad_oe,
  input logic [DW-1:0] bus_ad_o
);
  p_hold_wait_r3: assert property (@(posedge clk) disable iff (rst)
    (!bus_mrdy_n && bus_srdy_n && bus_ad_oe) |=> (!bus_mrdy_n && $stable(bus_ad_o)));

  p_last_frame_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_cyc_n) |-> !bus_mrdy_n);

  p_frame_stays_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_cyc_n && !bus_mrdy_n) |=> bus_cyc_n);

  p_turnaround_r6: assert property (@(posedge clk) disable iff (rst)
    ($fell(bus_cyc_n) && bus_cmd_o == CMD_MEM_RD) |=> (!bus_ad_oe && bus_mrdy_n));

  p_end_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (!bus_mrdy_n && !bus_srdy_n && bus_cyc_n) |=> (bus_cyc_n && bus_mrdy_n && !bus_ad_oe));

  p_ready_idle_r7: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (bus_cyc_n && bus_mrdy_n));

  p_addr_step_r9: assert property (@(posedge clk) disable iff (rst)
    (!bus_mrdy_n && !bus_srdy_n && !bus_cyc_n) |=> (cur_addr == $past(cur_addr) + AW'(1)));

  p_read_out_r10: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(!bus_mrdy_n && !bus_srdy_n && !bus_ad_oe));

  p_byte_en_r11: assert property (@(posedge clk) disable iff (rst)
    !bus_mrdy_n |-> (bus_cmd_o == BE_ALL));
endmodule

bind burst_initiator bi_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .rd_valid(rd_valid),
  .cur_addr(cur_addr), .bus_cyc_n(bus_cyc_n), .bus_mrdy_n(bus_mrdy_n),
  .bus_srdy_n(bus_srdy_n), .bus_cmd_o(bus_cmd_o), .bus_ad_oe(bus_ad_oe),
  .bus_ad_o(bus_ad_o)
);

// File: tb/burst_initiator_test.sv
`timescale 1ns/1ps
module burst_initiator_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [2:0]  req_len = '0;
  logic        wr_valid = 1'b0;
  logic [15:0] wr_data = '0;
  logic        bus_srdy_n = 1'b1;
  logic [15:0] bus_ad_i = '0;
  logic        req_ready, wr_ready, rd_valid;
  logic [15:0] rd_data, bus_ad_o;
  logic [7:0]  cur_addr;
  logic        bus_cyc_n, bus_mrdy_n, bus_ad_oe;
  logic [3:0]  bus_cmd_o;

  int n_checks = 0;
  int n_errs = 0;
  bit finished = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  burst_initiator #(.DW(16), .AW(8), .LW(3)) uut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_len(req_len),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_data(rd_data), .cur_addr(cur_addr),
    .bus_cyc_n(bus_cyc_n), .bus_mrdy_n(bus_mrdy_n), .bus_srdy_n(bus_srdy_n),
    .bus_cmd_o(bus_cmd_o), .bus_ad_oe(bus_ad_oe), .bus_ad_o(bus_ad_o),
    .bus_ad_i(bus_ad_i)
  );

  function automatic logic [15:0] rdat(input logic [7:0] a);
    return {a ^ 8'hC0, a};
  endfunction

  function automatic logic [15:0] wdat(input logic [7:0] a);
    return {a, a ^ 8'h3C};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
    end
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic run_burst(input bit wr, input logic [7:0] st, input int len, input int mode);
    int words = len + 1;
    int xf = 0;
    int fe = 0;
    int idx = 0;
    bit held = 1'b0;
    bit pend_rd = 1'b0;
    bit prev_wait = 1'b0;
    bit x, f;
    logic [15:0] pend_val = '0;
    logic [15:0] prev_ad = '0;

    chk(req_ready === 1'b1, "R2 ready before request", 32'(req_ready), 1);
    req_valid = 1'b1; req_write = wr; req_addr = st; req_len = 3'(len);
    @(negedge clk);
    req_valid = 1'b0;
    // R2: address phase
    chk(!bus_cyc_n && bus_ad_oe && bus_ad_o == 16'(st), "R2 address phase",
        32'(bus_ad_o), 32'(st));
    chk(bus_cmd_o == (wr ? 4'b0111 : 4'b0110), "R2 command", 32'(bus_cmd_o),
        wr ? 32'h7 : 32'h6);
    while (xf < words && idx < 400) begin
      if (idx > 0) begin
        // R5: framing high only with ready low and one word left
        chk(bus_cyc_n == (!bus_mrdy_n && xf == len), "R5 framing", 32'(bus_cyc_n),
            32'(!bus_mrdy_n && xf == len));
        if (!wr && idx == 1)
          chk(!bus_ad_oe && bus_mrdy_n, "R6 turnaround", {bus_ad_oe, bus_mrdy_n}, 32'b01);
        if (!wr && idx >= 2)
          chk(!bus_mrdy_n, "R6 read ready held", 32'(bus_mrdy_n), 0);
        if (wr)
          chk(bus_mrdy_n == !held, "R8 ready follows held word", 32'(bus_mrdy_n), 32'(!held));
        if (prev_wait)
          chk(bus_ad_o == prev_ad, "R3 data held in wait", 32'(bus_ad_o), 32'(prev_ad));
        if (!bus_mrdy_n)
          chk(bus_cmd_o == 4'b0000, "R11 byte enables", 32'(bus_cmd_o), 0);
        if (pend_rd)
          chk(rd_valid && rd_data == pend_val, "R10 read word", 32'(rd_data), 32'(pend_val));
        else
          chk(!rd_valid, "R10 no read word", 32'(rd_valid), 0);
      end
      step_lfsr();
      case (mode)
        0:       bus_srdy_n = 1'b0;
        1:       bus_srdy_n = lfsr[0];
        default: bus_srdy_n = (lfsr[2:1] != 2'b00);
      endcase
      bus_ad_i = rdat(8'(st + xf));
      if (wr && fe < words) begin
        case (mode)
          0:       wr_valid = 1'b1;
          1:       wr_valid = !lfsr[7];
          default: wr_valid = lfsr[9] & lfsr[8];
        endcase
      end else begin
        wr_valid = 1'b0;
      end
      wr_data = wdat(8'(st + fe));
      #1;
      x = !bus_mrdy_n && !bus_srdy_n;
      f = wr_valid && wr_ready;
      if (wr && fe == words)
        chk(!wr_ready, "R4 no extra local word", 32'(wr_ready), 0);
      if (x) begin
        chk(cur_addr == 8'(st + xf), "R9 address", 32'(cur_addr), 32'(8'(st + xf)));
        if (wr)
          chk(bus_ad_oe && bus_ad_o == wdat(8'(st + xf)), "R3 write word",
              32'(bus_ad_o), 32'(wdat(8'(st + xf))));
      end
      prev_wait = wr && !bus_mrdy_n && bus_srdy_n;
      prev_ad   = bus_ad_o;
      pend_rd   = x && !wr;
      pend_val  = rdat(8'(st + xf));
      held      = f || (held && !x);
      if (x) xf++;
      if (f) fe++;
      idx++;
      @(negedge clk);
    end
    bus_srdy_n = 1'b1;
    wr_valid   = 1'b0;
    chk(xf == words, "R4 word count", 32'(xf), 32'(words));
    if (wr) chk(fe == words, "R4 local words taken", 32'(fe), 32'(words));
    // R7: idle after final transfer
    chk(bus_cyc_n && bus_mrdy_n && !bus_ad_oe && req_ready, "R7 idle after burst",
        {bus_cyc_n, bus_mrdy_n, bus_ad_oe, req_ready}, 32'b1101);
    if (!wr)
      chk(pend_rd && rd_valid && rd_data == pend_val, "R10 last read word",
          32'(rd_data), 32'(pend_val));
    @(negedge clk);
    chk(!rd_valid && bus_cyc_n, "R7 R10 quiet idle", {rd_valid, bus_cyc_n}, 32'b01);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk(bus_cyc_n && bus_mrdy_n && !bus_ad_oe && req_ready && !rd_valid, "R1 reset state",
        {bus_cyc_n, bus_mrdy_n, bus_ad_oe, req_ready, rd_valid}, 32'b11010);
    for (int wr = 0; wr < 2; wr++) begin
      for (int mode = 0; mode < 3; mode++) begin
        for (int len = 0; len < 8; len++) begin
          run_burst(wr[0], 8'(8'hF0 + len * 37 + mode * 11 + wr * 5), len, mode);
        end
      end
    end
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_errs++;
    $display("FAIL R4 watchdog: actual hung expected done");
    report();
  end
endmodule